// File: doc/BRIEF.md
# Glitch-Free Group Clock Stop Controller

This block divides a fast reference clock into one group of identical output clocks and can stop that group in response to an asynchronous, active-low stop request. The request is first brought into the group's own timing through a chain of flops sampled on the group's rising edges. The gate opens and closes only where a low phase begins. As a result, a stopped group always rests low, and every high pulse has full width, including the first pulse after a restart.

After reset, and again after every restart, the group must deliver a minimum number of pulses before another stop can take effect. A stop request that is seen during that window is held pending. It is applied when the window ends, even if the request has been withdrawn by then. A companion free-running output at the same frequency is never gated. A status flag reports whether the group is currently parked.

The same block serves a slow bus group and a fast processor group through its parameters. These set the division ratio, the minimum pulse count, the lane count and the synchronizer depth. A group-enable input qualifies every fast-clock step, so the whole block freezes while the enable is low.

Top module: `clkstop_ctrl`

## Requirements
- R1: The stop request acts only through values sampled on group rising edges. The gate decision uses the value sampled at the rising edge before the most recent one. A low pulse on `stop_n` that spans no group rising edge has no effect.
- R2: While `stopped_o` is 1, all gated lanes are 0. `stopped_o` changes only on an edge where `free_clk_o` is, after that edge, 0.
- R3: With `grp_en` held at 1, every high pulse on a gated lane lasts exactly DIV/2 fast cycles. This includes the first pulse after a restart.
- R4: With `grp_en` held at 1, `stopped_o` rises within 3 rising edges of `free_clk_o` after `stop_n` falls, provided the minimum window has ended. After `stop_n` rises again, the gated lanes rise again no later than the 3rd rising edge of `free_clk_o`.
- R5: After reset, and after each restart, the gated lanes deliver exactly MIN_ON rising edges before a held stop request parks them.
- R6: A stop request that is seen during the minimum window is kept pending. The group parks as soon as the window ends, even if `stop_n` has returned to 1, and then restarts.
- R7: `free_clk_o` has period DIV, with a high phase of DIV/2, whenever `grp_en` is 1. The stop request does not affect it.
- R8: While `grp_en` is 0, every output holds its value, and `stop_n` is not sampled.
- R9: Reset (`rst_n` low, asynchronous) drives all outputs to 0. The first fast cycle with `grp_en`=1 after reset raises both `free_clk_o` and the gated lanes.
- R10: All gated lanes carry the same value on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_en | input | 1 | Fast-cycle qualifier; the divider and all state advance only when 1 |
| stop_n | input | 1 | Asynchronous active-low stop request for the group |
| gclk_o | output | N_OUT | Gated group clock lanes |
| free_clk_o | output | 1 | Ungated group clock at the same frequency |
| stopped_o | output | 1 | 1 while the gated group is parked low |

## Verification
The stop request is applied in several patterns, and each one separates a different behaviour:
- A request raised right after reset and withdrawn early separates pending-stop handling from plain level following.
- A request held through a long run measures the off latency.
- A request held across a restart checks that exactly MIN_ON pulses are delivered.
- A narrow pulse placed between group rising edges distinguishes edge-sampled synchronization from a direct level path.
- Pauses of `grp_en` with `stop_n` toggled inside them show that the request is not sampled and that every output holds while paused.
- A long pseudo-random mix of request toggles and enable gaps is compared on every cycle against a behavioural model. This catches wrong pulse widths and lanes that drift apart.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic {
    GS_RUN  = 1'b0,
    GS_HALT = 1'b1
  } gate_state_e;

  // Phase step of the divider: wraps from div-1 back to 0.
  function automatic int unsigned next_phase(input int unsigned ph, input int unsigned div);
    return (ph == div - 1) ? 32'd0 : ph + 32'd1;
  endfunction

  // Group clock level for a given phase: high for the first half period.
  function automatic logic phase_high(input int unsigned ph, input int unsigned half);
    return ph < half;
  endfunction

endpackage

// File: rtl/clkstop_divider.sv
module clkstop_divider #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic nxt_high,
  output logic rise_ev,
  output logic fall_ev
);
  import clkstop_pkg::*;

  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned PW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PW-1:0] ph;
  logic [PW-1:0] ph_nxt;

  always_comb begin
    ph_nxt   = adv ? PW'(next_phase(32'(ph), DIV)) : ph;
    nxt_high = phase_high(32'(ph_nxt), HALF);
    rise_ev  = adv && (ph == PW'(DIV - 1));
    fall_ev  = adv && (ph == PW'(HALF - 1));
  end

  // Reset parks the phase at the end of a low half so the first step rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PW'(DIV - 1);
    else        ph <= ph_nxt;
  end

endmodule

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int unsigned LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic d,
  output logic q
);
  logic [LEN-1:0] stage;

  for (genvar g = 0; g < LEN; g++) begin : g_stage
    logic src;
    if (g == 0) begin : g_head
      assign src = d;
    end else begin : g_tail
      assign src = stage[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage[g] <= 1'b1;
      else if (sample) stage[g] <= src;
    end
  end

  assign q = stage[LEN-1];

endmodule

// File: rtl/clkstop_gate_ctl.sv
module clkstop_gate_ctl #(
  parameter int unsigned MIN_ON = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_ev,
  input  logic fall_ev,
  input  logic req_stop,
  output logic gate_q,
  output logic gate_nxt,
  output logic win_done,
  output logic pend_q
);
  import clkstop_pkg::*;

  localparam int unsigned CW = $clog2(MIN_ON + 1);

  gate_state_e   st_q;
  gate_state_e   st_nxt;
  logic [CW-1:0] cnt_q;
  logic          turn_on;
  logic          turn_off;

  assign gate_q   = (st_q == GS_RUN);
  assign win_done = (cnt_q == CW'(MIN_ON));

  always_comb begin
    turn_off = fall_ev && gate_q && (req_stop || pend_q) && win_done;
    turn_on  = fall_ev && !gate_q && !req_stop;
    st_nxt   = st_q;
    if (turn_off)     st_nxt = GS_HALT;
    else if (turn_on) st_nxt = GS_RUN;
    gate_nxt = (st_nxt == GS_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= GS_RUN;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q <= st_nxt;
      if (turn_on)                             cnt_q <= '0;
      else if (rise_ev && gate_q && !win_done) cnt_q <= cnt_q + CW'(1);
      if (turn_off)                                       pend_q <= 1'b0;
      else if (fall_ev && gate_q && req_stop && !win_done) pend_q <= 1'b1;
    end
  end

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int unsigned DIV      = 4,
  parameter int unsigned MIN_ON   = 10,
  parameter int unsigned N_OUT    = 7,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_en,
  input  logic             stop_n,
  output logic [N_OUT-1:0] gclk_o,
  output logic             free_clk_o,
  output logic             stopped_o
);
  // Named internal events, also observed by the bound checker.
  logic nxt_high;
  logic rise_ev;
  logic fall_ev;
  logic sync_q;
  logic sync_req;
  logic gate_q;
  logic gate_nxt;
  logic win_done;
  logic pend;
  logic free_q;

  clkstop_divider #(.DIV(DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (grp_en),
    .nxt_high (nxt_high),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev)
  );

  clkstop_sync #(.LEN(SYNC_LEN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (rise_ev),
    .d      (stop_n),
    .q      (sync_q)
  );

  assign sync_req = !sync_q;

  clkstop_gate_ctl #(.MIN_ON(MIN_ON)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .req_stop (sync_req),
    .gate_q   (gate_q),
    .gate_nxt (gate_nxt),
    .win_done (win_done),
    .pend_q   (pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= 1'b0;
    else        free_q <= nxt_high;
  end
  assign free_clk_o = free_q;

  // One output flop per lane keeps each gated clock glitch free.
  for (genvar g = 0; g < N_OUT; g++) begin : g_lane
    logic lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= 1'b0;
      else        lane_q <= nxt_high && gate_nxt;
    end
    assign gclk_o[g] = lane_q;
  end

  assign stopped_o = !gate_q;

endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
  parameter int unsigned DIV    = 4,
  parameter int unsigned MIN_ON = 10,
  parameter int unsigned N_OUT  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             grp_en,
  input logic [N_OUT-1:0] gclk,
  input logic             free_clk,
  input logic             stopped,
  input logic             rise_ev,
  input logic             fall_ev,
  input logic             sync_req,
  input logic             pend
);
  logic        live;
  logic        prev_g;
  int unsigned n_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= 1'b0;
      prev_g <= 1'b0;
      n_rise <= 0;
    end else begin
      live   <= 1'b1;
      prev_g <= gclk[0];
      if (stopped)                n_rise <= 0;
      else if (gclk[0] && !prev_g) n_rise <= n_rise + 1;
    end
  end

  a_r1_sync_stable: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(!rise_ev) |-> $stable(sync_req));

  a_r1_stop_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
    live && $rose(stopped) |-> $past(sync_req || pend));

  a_r2_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (gclk == '0));

  a_r2_halt_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    live && $rose(stopped) |-> !free_clk);

  a_r2_resume_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    live && $fell(stopped) |-> !free_clk);

  a_r5_min_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    live && $rose(stopped) |-> (n_rise >= MIN_ON));

  a_r7_free_rise: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(rise_ev) |-> free_clk);

  a_r7_free_fall: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(fall_ev) |-> !free_clk);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(!grp_en) |-> $stable(free_clk) && $stable(gclk) && $stable(stopped));

  a_r10_lanes_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (gclk == '0) || (&gclk));

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
  .DIV(DIV), .MIN_ON(MIN_ON), .N_OUT(N_OUT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .grp_en   (grp_en),
  .gclk     (gclk_o),
  .free_clk (free_clk_o),
  .stopped  (stopped_o),
  .rise_ev  (rise_ev),
  .fall_ev  (fall_ev),
  .sync_req (sync_req),
  .pend     (pend)
);

// File: tb/clkstop_ctrl_test.sv
module clkstop_ctrl_test;
  localparam int DIV = 4, HALF = DIV / 2, MIN_ON = 10, N_OUT = 7;

  logic clk = 1'b0, rst_n = 1'b0, grp_en = 1'b1, stop_n = 1'b1;
  logic [N_OUT-1:0] gclk;
  logic fclk, stopped;

  always #5 clk = ~clk;

  clkstop_ctrl #(.DIV(DIV), .MIN_ON(MIN_ON), .N_OUT(N_OUT), .SYNC_LEN(2)) uut (
    .clk(clk), .rst_n(rst_n), .grp_en(grp_en), .stop_n(stop_n),
    .gclk_o(gclk), .free_clk_o(fclk), .stopped_o(stopped)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: phase counter, two request samples, run window.
  int m_pos = DIV - 1, m_cnt = 0;
  bit m_s1 = 1, m_s2 = 1, m_run = 1, m_pend = 0, m_rst = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = DIV - 1; m_s1 = 1; m_s2 = 1; m_run = 1; m_cnt = 0; m_pend = 0; m_rst = 1;
    end else begin
      m_rst = 0;
      if (grp_en) begin
        m_pos = (m_pos + 1) % DIV;
        if (m_pos == 0) begin
          m_s2 = m_s1; m_s1 = stop_n;
          if (m_run && m_cnt < MIN_ON) m_cnt++;
        end
        if (m_pos == HALF) begin
          if (m_run) begin
            if (!m_s2 && m_cnt < MIN_ON) m_pend = 1;
            else if ((!m_s2 || m_pend) && m_cnt >= MIN_ON) begin m_run = 0; m_pend = 0; end
          end else if (m_s2) begin
            m_run = 1; m_cnt = 0;
          end
        end
      end
    end
  end

  // Monitors, sampled on the falling edge.
  bit p_g = 0, p_f = 0, p_s = 0, width_on = 0;
  int free_rises = 0, g_since = 0, stop_events = 0, rises_at_stop = 0, run_len = 0;

  always @(negedge clk) begin
    bit ef;
    logic [N_OUT-1:0] eg;
    if (!m_rst) begin
      ef = (m_pos < HALF);
      eg = (ef && m_run) ? '1 : '0;
      chk(fclk === ef && gclk === eg && stopped === !m_run, "R2 R7 R10 model",
          int'({stopped, fclk, gclk}), int'({!m_run, ef, eg}));
      if (fclk && !p_f) free_rises++;
      if (gclk[0] && !p_g) g_since++;
      if (stopped && !p_s) begin stop_events++; rises_at_stop = g_since; end
      if (!stopped && p_s) g_since = 0;
      if (gclk[0]) run_len++;
      else begin
        if (p_g && width_on) chk(run_len == HALF, "R3 high pulse width", run_len, HALF);
        run_len = 0;
      end
      p_g = gclk[0]; p_f = fclk; p_s = stopped;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int f0, k, ev0;
    logic [N_OUT+1:0] snap;
    bit held;
    logic [15:0] lf;

    step(3);
    chk(gclk == '0 && fclk == 0 && stopped == 0, "R9 reset outputs",
        int'({stopped, fclk, gclk}), 0);
    rst_n = 1; stop_n = 0; width_on = 1;
    step(1);
    chk(fclk == 1 && gclk == '1, "R9 first enabled cycle rises", int'({fclk, gclk[0]}), 3);

    // Early request, withdrawn inside the minimum window.
    step(11); stop_n = 1;
    step(80);
    chk(stop_events == 1, "R6 pending stop applied", stop_events, 1);
    chk(rises_at_stop == MIN_ON, "R5 pulses before stop after reset", rises_at_stop, MIN_ON);
    chk(stopped == 0, "R6 restarted after pending stop", stopped, 0);

    // Off latency with the window long finished.
    step(60);
    stop_n = 0; f0 = free_rises; k = 0;
    while (!stopped && k < 40) begin step(1); k++; end
    chk(stopped && (free_rises - f0) <= 3, "R4 off latency", free_rises - f0, 3);
    f0 = free_rises;
    step(40);
    chk(free_rises - f0 == 10, "R7 free clock keeps running", free_rises - f0, 10);
    chk(gclk == '0 && stopped, "R2 parked low while stopped", int'(gclk), 0);

    // On latency, then a held request right after restart.
    stop_n = 1; f0 = free_rises; k = 0;
    while (!gclk[0] && k < 40) begin step(1); k++; end
    chk(gclk[0] && (free_rises - f0) <= 3, "R4 on latency", free_rises - f0, 3);
    stop_n = 0; k = 0;
    while (stop_events < 3 && k < 200) begin step(1); k++; end
    chk(rises_at_stop == MIN_ON, "R5 pulses before stop after restart", rises_at_stop, MIN_ON);
    stop_n = 1;
    step(60);

    // Pause: outputs hold and the request is not sampled.
    width_on = 0; grp_en = 0; step(1);
    snap = {stopped, fclk, gclk}; held = 1; ev0 = stop_events;
    stop_n = 0;
    for (int i = 0; i < 15; i++) begin
      step(1);
      if ({stopped, fclk, gclk} !== snap) held = 0;
    end
    chk(held, "R8 outputs hold while paused", int'(held), 1);
    stop_n = 1; step(1); grp_en = 1;
    step(40);
    chk(stop_events == ev0 && !stopped, "R8 request ignored while paused", stop_events, ev0);
    width_on = 1;

    // Narrow pulse between group rising edges.
    step(60);
    ev0 = stop_events;
    while (m_pos != 1) step(1);
    stop_n = 0; step(1); stop_n = 1;
    step(30);
    chk(stop_events == ev0 && !stopped, "R1 narrow pulse filtered", stop_events, ev0);

    // Mixed stress against the model.
    width_on = 0; lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      step(1);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[3:0] == 4'd0) stop_n = ~stop_n;
      grp_en = (lf[7:5] != 3'd0);
    end
    chk(stop_events > ev0, "R1 stress produced stops", stop_events, ev0 + 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule